// File: doc/BRIEF.md
# Self-Clearing Soft Reset Sequencer

This block runs the reset sequencing of a network controller that contains its own PHY. The host sees three registers. The first is a device configuration register with a self-clearing soft-reset bit. The second is a power-management control register with a self-clearing PHY reset bit and a READY flag. The third is a copy of the PHY basic control register, whose top bit is also a self-clearing reset. Each trigger loads its own down-counter. While that counter is non-zero, the matching reset bit reads 1 and the block drives an internal reset line. The three lengths are parameters that default to about 2 µs, 100 µs and 50 µs of core clock.

A device soft reset returns the ordinary configuration fields to their defaults and holds them there. The fields marked as surviving soft reset are left alone. Host writes are refused until the reset ends. A PHY reset from either trigger holds the lower bits of the PHY control copy at their default. READY tells software when every reset has finished.

Top module: `srst_seq`

## Requirements
- R1: After the synchronous reset `rst_i`: address 0 reads 0x0000_0500, address 1 reads 0x0000_0005 and address 2 reads 0x0000_3100. `dev_rst_o` and `phy_rst_o` are 0 and `ready_o` is 1.
- R2: Address 0 holds `keep_cfg` in [23:16], `gen_cfg` in [15:8] (default 0x05) and the device reset bit in [0]. A write to address 0 with bit 0 set starts a device reset. Bit 0 and `dev_rst_o` read 1 for exactly DEV_RST_CYCLES cycles, counted from the edge that accepts the write. A write with bit 0 set changes no other field.
- R3: From the accepting edge until the device reset ends, `gen_cfg` reads 0x05 and `gen_pm` (address 1 bits [3:1]) reads 3'b010. `keep_cfg` and `keep_pm` (address 1 bits [7:4]) keep their values through the reset.
- R4: While a device reset is counting, writes to every address are ignored. This includes writes that would start a PHY reset.
- R5: Address 1 holds the PHY reset bit in [10]. Writing it as 1 makes the bit and `phy_rst_o` read 1 for exactly PM_RST_CYCLES cycles. The other writable fields of that write are stored.
- R6: Address 2 holds the PHY reset bit in [15] and `gen_bc` in [14:0]. Writing bit 15 as 1 makes it read 1 and drives `phy_rst_o` high for exactly BC_RST_CYCLES cycles.
- R7: While either PHY reset is counting, from its accepting edge, `gen_bc` reads 0x3100 and writes to it are ignored. A write with bit 15 set discards its lower bits.
- R8: READY (address 1 bit 0 and `ready_o`) is 0 while any reset counter runs and 1 otherwise.
- R9: Writing 1 to a reset bit whose counter is already running does not restart the counter.
- R10: Writing 0 to a reset bit has no effect. Address 1 bit 0 is read-only.
- R11: Address 3 and unused bit positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high hard reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register index |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read register index |
| rd_data_o | output | 32 | Read data for rd_addr_i (combinational) |
| dev_rst_o | output | 1 | Internal device reset pulse |
| phy_rst_o | output | 1 | Internal PHY reset pulse |
| ready_o | output | 1 | Device operational |

## Verification
The bench builds the block with reset lengths of 6, 20 and 11 cycles instead of the microsecond defaults. Each pulse therefore completes within a few dozen cycles, and its exact first and last cycles can be compared against the model. With these short windows the bench can also overlap a PHY reset from the power-management register with one from the PHY control copy, and it can re-trigger each counter in the middle of its count. It can also issue a device reset while a PHY reset is running and observe READY staying low until the later of the two ends.

// File: rtl/srst_pkg.sv
package srst_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 2;

    typedef enum logic [AW-1:0] {
        REG_CFG    = 2'd0,
        REG_PM     = 2'd1,
        REG_PHYCTL = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    localparam int unsigned NUM_TIMERS = 3;
    localparam int unsigned T_DEV = 0;
    localparam int unsigned T_PM  = 1;
    localparam int unsigned T_BC  = 2;

    localparam int unsigned CFG_RST_BIT = 0;
    localparam int unsigned PM_RST_BIT  = 10;
    localparam int unsigned BC_RST_BIT  = 15;

    localparam logic [7:0]  GEN_CFG_DEF = 8'h05;
    localparam logic [2:0]  GEN_PM_DEF  = 3'b010;
    localparam logic [14:0] GEN_BC_DEF  = 15'h3100;

    typedef struct packed {
        logic [7:0]  keep_cfg;
        logic [7:0]  gen_cfg;
        logic [3:0]  keep_pm;
        logic [2:0]  gen_pm;
        logic [14:0] gen_bc;
    } reg_state_t;

    function automatic logic [DW-1:0] pack_cfg(input reg_state_t s, input logic busy);
        return {8'h00, s.keep_cfg, s.gen_cfg, 7'h00, busy};
    endfunction

    function automatic logic [DW-1:0] pack_pm(input reg_state_t s, input logic busy, input logic rdy);
        return {21'h0, busy, 2'b00, s.keep_pm, s.gen_pm, rdy};
    endfunction

    function automatic logic [DW-1:0] pack_bc(input reg_state_t s, input logic busy);
        return {16'h0, busy, s.gen_bc};
    endfunction

endpackage

// File: rtl/srst_timer.sv
module srst_timer #(
    parameter int unsigned LEN = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (start_i && cnt_q == '0)
            cnt_q <= CW'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R9: a trigger while counting keeps the count going down
    a_r9_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && start_i) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

    // R2: an accepted trigger loads the full length
    a_r2_full_load: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && start_i) |=> (cnt_q == CW'(LEN)));

endmodule

// File: rtl/srst_regs.sv
module srst_regs
    import srst_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic            dev_start_i,
    input  logic            dev_busy_i,
    input  logic            pm_busy_i,
    input  logic            bc_busy_i,
    input  logic            phy_hold_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [DW-1:0]   rd_data_o
);
    reg_state_t st_q;
    logic       wr_ok;
    logic       ready;

    assign wr_ok = wr_en_i && !dev_busy_i;
    assign ready = !(dev_busy_i || pm_busy_i || bc_busy_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.keep_cfg <= '0;
            st_q.keep_pm  <= '0;
        end else if (wr_ok) begin
            if (reg_sel_e'(wr_addr_i) == REG_CFG && !wr_data_i[CFG_RST_BIT])
                st_q.keep_cfg <= wr_data_i[23:16];
            if (reg_sel_e'(wr_addr_i) == REG_PM)
                st_q.keep_pm <= wr_data_i[7:4];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || dev_start_i || dev_busy_i) begin
            st_q.gen_cfg <= GEN_CFG_DEF;
            st_q.gen_pm  <= GEN_PM_DEF;
        end else if (wr_en_i) begin
            if (reg_sel_e'(wr_addr_i) == REG_CFG)
                st_q.gen_cfg <= wr_data_i[15:8];
            if (reg_sel_e'(wr_addr_i) == REG_PM)
                st_q.gen_pm <= wr_data_i[3:1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || phy_hold_i)
            st_q.gen_bc <= GEN_BC_DEF;
        else if (wr_ok && reg_sel_e'(wr_addr_i) == REG_PHYCTL && !wr_data_i[BC_RST_BIT])
            st_q.gen_bc <= wr_data_i[14:0];
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr_i))
            REG_CFG:    rd_data_o = pack_cfg(st_q, dev_busy_i);
            REG_PM:     rd_data_o = pack_pm(st_q, pm_busy_i, ready);
            REG_PHYCTL: rd_data_o = pack_bc(st_q, bc_busy_i);
            default:    rd_data_o = '0;
        endcase
    end

    // R3 and R4: preserved fields do not move while the device reset runs
    a_r3_keep_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        dev_busy_i |=> ($stable(st_q.keep_cfg) && $stable(st_q.keep_pm)));

    // R4: PHY control copy is not written during a device reset
    a_r4_bc_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (dev_busy_i && !pm_busy_i && !bc_busy_i) |=> $stable(st_q.gen_bc));

    // R7: a PHY reset leaves the lower control bits at their default
    a_r7_bc_default: assert property (@(posedge clk_i) disable iff (rst_i)
        (pm_busy_i || bc_busy_i) |-> (st_q.gen_bc == GEN_BC_DEF));

endmodule

// File: rtl/srst_seq.sv
module srst_seq
    import srst_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 250,
    parameter int unsigned DEV_RST_CYCLES = CLK_MHZ * 2,
    parameter int unsigned PM_RST_CYCLES  = CLK_MHZ * 100,
    parameter int unsigned BC_RST_CYCLES  = CLK_MHZ * 50
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [31:0]   wr_data_i,
    input  logic [1:0]    rd_addr_i,
    output logic [31:0]   rd_data_o,
    output logic          dev_rst_o,
    output logic          phy_rst_o,
    output logic          ready_o
);
    localparam int unsigned TLEN [NUM_TIMERS] = '{DEV_RST_CYCLES, PM_RST_CYCLES, BC_RST_CYCLES};
    localparam int unsigned TBIT [NUM_TIMERS] = '{CFG_RST_BIT, PM_RST_BIT, BC_RST_BIT};

    logic [NUM_TIMERS-1:0] start;
    logic [NUM_TIMERS-1:0] busy;
    logic                  phy_hold;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        assign start[g] = wr_en_i && !busy[T_DEV] && !busy[g]
                          && (wr_addr_i == AW'(g)) && wr_data_i[TBIT[g]];

        srst_timer #(.LEN(TLEN[g])) u_tmr (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .start_i (start[g]),
            .busy_o  (busy[g])
        );
    end

    assign phy_hold = start[T_PM] || start[T_BC] || busy[T_PM] || busy[T_BC];

    srst_regs u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .dev_start_i (start[T_DEV]),
        .dev_busy_i  (busy[T_DEV]),
        .pm_busy_i   (busy[T_PM]),
        .bc_busy_i   (busy[T_BC]),
        .phy_hold_i  (phy_hold),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o)
    );

    assign dev_rst_o = busy[T_DEV];
    assign phy_rst_o = busy[T_PM] | busy[T_BC];
    assign ready_o   = ~|busy;

    // R8: any accepted trigger drops READY on the next cycle
    a_r8_ready_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        (|start) |=> !ready_o);

    // R4: no PHY reset can begin while the device reset counts
    a_r4_no_phy_start: assert property (@(posedge clk_i) disable iff (rst_i)
        dev_rst_o |-> !(start[T_PM] || start[T_BC]));

    // R2: device reset output rises only after an accepted trigger
    a_r2_dev_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dev_rst_o) |-> $past(start[T_DEV]));

endmodule

// File: tb/srst_seq_bench.sv
module srst_seq_bench;
    localparam int B_DEV = 6;
    localparam int B_PM  = 20;
    localparam int B_BC  = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dev_rst, phy_rst, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    always #2 clk = ~clk;

    srst_seq #(
        .DEV_RST_CYCLES(B_DEV), .PM_RST_CYCLES(B_PM), .BC_RST_CYCLES(B_BC)
    ) u_srst_seq (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .dev_rst_o(dev_rst), .phy_rst_o(phy_rst), .ready_o(ready)
    );

    // behavioural reference model
    int m_dev, m_pm, m_bc;
    int m_kcfg, m_gcfg, m_kpm, m_gpm, m_gbc;

    always @(posedge clk) begin
        int nd, np, nb;
        if (rst) begin
            m_dev = 0; m_pm = 0; m_bc = 0;
            m_kcfg = 0; m_gcfg = 'h05; m_kpm = 0; m_gpm = 2; m_gbc = 'h3100;
            live = 1;
        end else begin
            nd = (m_dev > 0) ? m_dev - 1 : 0;
            np = (m_pm  > 0) ? m_pm  - 1 : 0;
            nb = (m_bc  > 0) ? m_bc  - 1 : 0;
            if (wr_en && m_dev == 0) begin
                case (wr_addr)
                    2'd0: if (wr_data[0]) nd = B_DEV;
                          else begin m_gcfg = wr_data[15:8]; m_kcfg = wr_data[23:16]; end
                    2'd1: begin
                        m_gpm = wr_data[3:1]; m_kpm = wr_data[7:4];
                        if (wr_data[10] && m_pm == 0) np = B_PM;
                    end
                    2'd2: if (wr_data[15]) begin
                              if (m_bc == 0) nb = B_BC;
                          end else if (m_pm == 0 && m_bc == 0) m_gbc = wr_data[14:0];
                    default: ;
                endcase
            end
            m_dev = nd; m_pm = np; m_bc = nb;
            if (m_dev > 0) begin m_gcfg = 'h05; m_gpm = 2; end
            if (m_pm > 0 || m_bc > 0) m_gbc = 'h3100;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        logic rdy;
        rdy = (m_dev == 0 && m_pm == 0 && m_bc == 0);
        case (a)
            2'd0: return {8'h0, 8'(m_kcfg), 8'(m_gcfg), 7'h0, 1'(m_dev > 0)};
            2'd1: return {21'h0, 1'(m_pm > 0), 2'b00, 4'(m_kpm), 3'(m_gpm), rdy};
            2'd2: return {16'h0, 1'(m_bc > 0), 15'(m_gbc)};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            check("R2 dev_rst_o", 32'(dev_rst), 32'(m_dev > 0));
            check("R5 R6 phy_rst_o", 32'(phy_rst), 32'(m_pm > 0 || m_bc > 0));
            check("R8 ready_o", 32'(ready), 32'(m_dev == 0 && m_pm == 0 && m_bc == 0));
            case (rd_addr)
                2'd0: check("R1 R2 R3 R4 cfg read", rd_data, model_read(2'd0));
                2'd1: check("R5 R8 R10 pm read", rd_data, model_read(2'd1));
                2'd2: check("R6 R7 phyctl read", rd_data, model_read(2'd2));
                default: check("R11 unused read", rd_data, model_read(2'd3));
            endcase
        end
    end

    always @(negedge clk) #1 rd_addr <= rd_addr + 2'd1;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr_en = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(4);                              // R1 reset values
        wr(2'd0, 32'h00AB_CD00);              // plain config write
        wr(2'd1, 32'h0000_00F7);              // R10 bit 0 read-only
        wr(2'd2, 32'h0000_1234);
        idle(4);
        wr(2'd0, 32'h0000_0001);              // R2 R3 device reset
        wr(2'd0, 32'h00FF_EE00);              // R4 ignored
        wr(2'd1, 32'h0000_0400);              // R4 PHY trigger ignored
        wr(2'd0, 32'h0000_0001);              // R9 re-trigger
        idle(10);
        wr(2'd1, 32'h0000_0436);              // R5 PHY reset, fields stored
        wr(2'd2, 32'h0000_0777);              // R7 ignored
        idle(4);
        wr(2'd1, 32'h0000_0400);              // R9 no restart
        wr(2'd1, 32'h0000_0030);              // R10 zero in reset bit
        idle(25);
        wr(2'd2, 32'h0000_8000);              // R6 PHY control reset
        idle(3);
        wr(2'd2, 32'h0000_8000);              // R9 no restart
        idle(12);
        wr(2'd2, 32'h0000_0055);
        wr(2'd1, 32'h0000_0400);              // overlapping PHY resets
        idle(5);
        wr(2'd2, 32'h0000_8123);              // R7 lower bits discarded
        idle(6);
        wr(2'd0, 32'h0000_0001);              // device reset during PHY reset
        idle(30);
        wr(2'd0, 32'h0012_3400);              // R10 zero in reset bit
        wr(2'd2, 32'h0000_0042);
        idle(8);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule